// File: doc/BRIEF.md
# Four-Channel Compare Match Timer

This block is a free-running 32-bit up-counter with four compare channels. The counter advances by one on every clock where the tick-enable input is high, and it wraps through zero. Each compare channel holds a value. When the counter steps onto that value, the channel records an event and raises its own interrupt line, provided its enable bit is set. Software reads and writes every register through a plain word-addressed port. Pending events are acknowledged by writing ones to the status register.

Channel 3 can also act as a one-shot watchdog. When it is armed and channel 3 matches, the block emits a single-cycle reset request and disarms itself. Eight further event sources, fed in from outside, share the status and enable registers in bits 4 to 11. They drive one combined interrupt output.

Top module: `match_timer`

## Requirements
- R1: On each clock with `tick_i` high and no count write, the count register goes up by one, wrapping from 0xFFFFFFFF to 0.
- R2: The interrupt-enable register (word 7) keeps only write-data bits 11:0; bits 31:12 read back as zero.
- R3: When the counter steps onto compare value n (words 0 to 3), status bit n and `irq_o[n]` are set only if enable bit n is 1. With the enable bit at 0, nothing changes.
- R4: A write to status (word 5) clears exactly the bits that are 1 both in the data and in the current status. `irq_o[n]` drops for each channel 0 to 3 whose bit is cleared.
- R5: `ext_evt_i[k]` sets status bit 4+k when enable bit 4+k is 1, and this raises `ext_irq_o`. `ext_irq_o` drops only after a status write that cleared at least one bit and left bits 11:4 all zero.
- R6: When channel 3 matches while watchdog bit 0 (word 6) is 1, `wdt_rst_o` pulses high for one clock and the watchdog bit returns to 0. This happens whatever the state of enable bit 3.
- R7: A write to the count register (word 4) takes effect on the next clock. Counting resumes from the written value.
- R8: A match fires only on the tick that makes the count equal to the compare value. Loading the count register with that value produces no match.
- R9: Word addresses 8 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| ext_evt_i | input | 8 | External event pulses for status bits 11:4 |
| irq_o | output | 4 | Per-channel compare interrupts |
| ext_irq_o | output | 1 | Combined interrupt for status bits 11:4 |
| wdt_rst_o | output | 1 | One-clock watchdog reset request |

## Verification
The hardest case to reach is the combined interrupt holding high through a status write that clears a low channel bit while an external bit is still pending. The stimulus first leaves channel 2 pending, then injects external events with only one of them enabled. It then issues three status writes: one that clears nothing, one that clears bit 2, and one that clears the external bit. Only the third write may drop `ext_irq_o`. The watchdog pulse lasts one cycle, so it is sampled in the half-cycle right after the matching tick. The disarmed watchdog bit is read back on the following clock.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int DW    = 32;
  localparam int NCMP  = 4;
  localparam int NEXT  = 8;
  localparam int NEVT  = NCMP + NEXT;
  // word offsets; compare channels occupy 0..NCMP-1
  localparam int A_CNT  = 4;
  localparam int A_STAT = 5;
  localparam int A_WDT  = 6;
  localparam int A_IER  = 7;
  localparam int WDT_CH = 3;
endpackage

// File: rtl/match_timer_counter.sv
module match_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_next_o,
  output logic         inc_o
);
  logic [W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + W'(1);
  assign inc_o      = tick_i & ~load_i;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/match_timer_cmp.sv
module match_timer_cmp #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic [W-1:0] cnt_next_i,
  output logic [W-1:0] val_o,
  output logic         match_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (we_i) val_q <= wdata_i;
  end

  // only a counting step can create a match, never a load
  assign match_o = inc_i && (cnt_next_i == val_q);
  assign val_o   = val_q;
endmodule

// File: rtl/match_timer_status.sv
module match_timer_status #(
  parameter int NC = 4,
  parameter int NE = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NC-1:0]  match_i,
  input  logic [NE-1:0]  ext_evt_i,
  input  logic [NC+NE-1:0] ier_i,
  input  logic           clr_we_i,
  input  logic [NC+NE-1:0] clr_data_i,
  output logic [NC+NE-1:0] status_o,
  output logic [NC-1:0]  irq_o,
  output logic           ext_irq_o
);
  localparam int N = NC + NE;

  logic [N-1:0]  stat_q, stat_d, set_v, clr_v;
  logic [NC-1:0] irq_q;
  logic          ext_q;

  assign set_v  = {ext_evt_i, match_i} & ier_i;
  assign clr_v  = clr_we_i ? (clr_data_i & stat_q) : '0;
  assign stat_d = (stat_q & ~clr_v) | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= '0;
      ext_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= (irq_q & ~clr_v[NC-1:0]) | set_v[NC-1:0];
      if (|set_v[N-1:NC])
        ext_q <= 1'b1;
      else if ((|clr_v) && !(|stat_d[N-1:NC]))
        ext_q <= 1'b0;
    end
  end

  assign status_o  = stat_q;
  assign irq_o     = irq_q;
  assign ext_irq_o = ext_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NEXT-1:0] ext_evt_i,
  output logic [NCMP-1:0] irq_o,
  output logic          ext_irq_o,
  output logic          wdt_rst_o
);
  logic [DW-1:0]   cnt, cnt_next;
  logic            inc;
  logic [DW-1:0]   cmp_val [NCMP];
  logic [NCMP-1:0] match;
  logic [NEVT-1:0] ier_q, stat;
  logic            wdt_q, wdt_pulse_q, wdt_fire;

  logic we_cnt, we_stat, we_wdt, we_ier;
  assign we_cnt  = reg_we_i && (reg_addr_i == AW'(A_CNT));
  assign we_stat = reg_we_i && (reg_addr_i == AW'(A_STAT));
  assign we_wdt  = reg_we_i && (reg_addr_i == AW'(A_WDT));
  assign we_ier  = reg_we_i && (reg_addr_i == AW'(A_IER));

  match_timer_counter #(.W(DW)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .load_i(we_cnt), .load_val_i(reg_wdata_i),
    .cnt_o(cnt), .cnt_next_o(cnt_next), .inc_o(inc)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    match_timer_cmp #(.W(DW)) u_cmp (
      .clk_i, .rst_ni,
      .we_i(reg_we_i && (reg_addr_i == AW'(g))),
      .wdata_i(reg_wdata_i),
      .inc_i(inc), .cnt_next_i(cnt_next),
      .val_o(cmp_val[g]), .match_o(match[g])
    );
  end

  match_timer_status #(.NC(NCMP), .NE(NEXT)) u_stat (
    .clk_i, .rst_ni,
    .match_i(match), .ext_evt_i(ext_evt_i), .ier_i(ier_q),
    .clr_we_i(we_stat), .clr_data_i(reg_wdata_i[NEVT-1:0]),
    .status_o(stat), .irq_o(irq_o), .ext_irq_o(ext_irq_o)
  );

  // watchdog fires on the raw match, independent of the interrupt enable
  assign wdt_fire = match[WDT_CH] & wdt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q       <= '0;
      wdt_q       <= 1'b0;
      wdt_pulse_q <= 1'b0;
    end else begin
      if (we_ier) ier_q <= reg_wdata_i[NEVT-1:0];
      wdt_pulse_q <= wdt_fire;
      if (wdt_fire)    wdt_q <= 1'b0;
      else if (we_wdt) wdt_q <= reg_wdata_i[0];
    end
  end
  assign wdt_rst_o = wdt_pulse_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < AW'(NCMP)) reg_rdata_o = cmp_val[reg_addr_i[1:0]];
    else if (reg_addr_i == AW'(A_CNT))  reg_rdata_o = cnt;
    else if (reg_addr_i == AW'(A_STAT)) reg_rdata_o = DW'(stat);
    else if (reg_addr_i == AW'(A_WDT))  reg_rdata_o = DW'(wdt_q);
    else if (reg_addr_i == AW'(A_IER))  reg_rdata_o = DW'(ier_q);
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import match_timer_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic [NCMP-1:0] irq_o,
  input logic          ext_irq_o,
  input logic          wdt_rst_o,
  input logic [DW-1:0] cnt,
  input logic [NEVT-1:0] stat,
  input logic          wdt_q
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(reg_we_i && reg_addr_i == AW'(A_CNT))) |=> cnt == $past(cnt) + 32'd1); // R1
  AST_IER_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AW'(A_IER)) |-> reg_rdata_o[31:NEVT] == '0); // R2
  AST_IRQ_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~stat[NCMP-1:0]) == '0); // R4
  AST_EXT_IRQ_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_o |-> (stat[NEVT-1:NCMP] != '0)); // R5
  AST_WDT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !wdt_q); // R6
  AST_WDT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R6
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(A_CNT)) |=> cnt == $past(reg_wdata_i)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > AW'(A_IER)) |-> reg_rdata_o == '0); // R9
endmodule

bind match_timer match_timer_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .tick_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .reg_rdata_o, .irq_o, .ext_irq_o, .wdt_rst_o,
  .cnt(cnt), .stat(stat), .wdt_q(wdt_q)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  ext_evt_i = '0;
  logic [3:0]  irq_o;
  logic        ext_irq_o, wdt_rst_o;

  match_timer u_dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // monitor: compare queued expectation at each falling edge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = reg_rdata_o;
        1: act = {28'd0, irq_o};
        2: act = {31'd0, ext_irq_o};
        default: act = {31'd0, wdt_rst_o};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic chk(input int sel, input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    #1;
    reg_addr_i = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i); #1;
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tick_i = 1'b0;
  endtask

  task automatic ext_pulse(input logic [7:0] m);
    @(negedge clk_i); #1;
    ext_evt_i = m;
    @(posedge clk_i); #1;
    ext_evt_i = '0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk(0, 6'd4, 32'h0, "R1 reset count");
    chk(0, 6'd5, 32'h0, "R4 reset status");
    chk(1, 6'd0, 32'h0, "R3 reset irq");
    chk(2, 6'd0, 32'h0, "R5 reset ext irq");

    wr(6'd7, 32'hFFFF_FFFF);
    chk(0, 6'd7, 32'h0000_0FFF, "R2 ier width");
    wr(6'd7, 32'h5);

    wr(6'd4, 32'h10);
    chk(0, 6'd4, 32'h10, "R7 count load");
    ticks(5);
    chk(0, 6'd4, 32'h15, "R1 count step");

    wr(6'd0, 32'h18);
    wr(6'd1, 32'h1A);
    wr(6'd2, 32'h1C);
    chk(0, 6'd1, 32'h1A, "R3 compare readback");
    ticks(3);
    chk(0, 6'd5, 32'h1, "R3 ch0 status");
    chk(1, 6'd0, 32'h1, "R3 ch0 irq");
    ticks(2);
    chk(0, 6'd5, 32'h1, "R3 disabled ch1 status");
    chk(1, 6'd0, 32'h1, "R3 disabled ch1 irq");
    ticks(2);
    chk(0, 6'd5, 32'h5, "R3 ch2 status");

    wr(6'd5, 32'h3);
    chk(0, 6'd5, 32'h4, "R4 w1c status");
    chk(1, 6'd0, 32'h4, "R4 w1c irq");

    wr(6'd4, 32'h18);
    chk(0, 6'd5, 32'h4, "R8 load gives no match");
    chk(0, 6'd4, 32'h18, "R7 reload");

    wr(6'd6, 32'h1);
    chk(0, 6'd6, 32'h1, "R6 armed");
    wr(6'd3, 32'h1A);
    ticks(2);
    chk(3, 6'd0, 32'h1, "R6 reset pulse");
    chk(3, 6'd6, 32'h0, "R6 pulse single");
    chk(0, 6'd6, 32'h0, "R6 disarmed");
    chk(0, 6'd5, 32'h4, "R3 ch3 disabled no status");

    wr(6'd7, 32'h14);
    ext_pulse(8'h03);
    chk(0, 6'd5, 32'h14, "R5 ext status");
    chk(2, 6'd0, 32'h1, "R5 ext irq up");
    wr(6'd5, 32'h1);
    chk(2, 6'd0, 32'h1, "R5 nothing cleared");
    wr(6'd5, 32'h4);
    chk(0, 6'd5, 32'h10, "R4 clear bit2");
    chk(2, 6'd0, 32'h1, "R5 ext pending holds");
    chk(1, 6'd0, 32'h0, "R4 irq2 dropped");
    wr(6'd5, 32'h10);
    chk(2, 6'd0, 32'h0, "R5 ext irq down");

    wr(6'd7, 32'h1);
    wr(6'd0, 32'h0);
    wr(6'd4, 32'hFFFF_FFFF);
    ticks(1);
    chk(0, 6'd4, 32'h0, "R1 wrap");
    chk(0, 6'd5, 32'h1, "R8 match at wrap");

    wr(6'd9, 32'hDEAD_BEEF);
    chk(0, 6'd9, 32'h0, "R9 unmapped read");
    chk(0, 6'd7, 32'h1, "R9 ier untouched");
    chk(0, 6'd0, 32'h0, "R9 cmp0 untouched");

    @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule